// File: doc/BRIEF.md
# Black-Level Clamp Loop Decoder

This block is the digital half of a black-level calibration loop for a two-channel image sensor front end. Each clock it reads a 14-bit straight-binary converter code from each channel and measures how far that code is from the black target of 512. A shared active-low clamp strobe marks the optical-black pixel interval. While the strobe is low, the block issues a direction bit and a 10-bit magnitude to each channel's charge-pump current DAC, which then nudges the offset of that channel toward black.

Near the target the magnitude equals the code error, so the analog loop settles exponentially. Above a code threshold of 1543 the magnitude is pinned at full scale and the loop slews linearly. Outside the clamp interval, or while standby is high, the magnitude is zero and no correction is applied. The analog DAC, the hold capacitor and the offset summing sit outside this block.

Top module: `oblk_clamp_loop`

## Requirements
- R1: A synchronous reset drives both magnitudes to 0 and both direction bits to 0 at the next clock edge.
- R2: When the clamp strobe `clampN` is high, the next registered magnitude of both channels is 0 and both direction bits keep their values.
- R3: When `standby` is high, the clamp strobe is treated as inactive: both magnitudes become 0 and both direction bits hold, even if `clampN` is low.
- R4: In the clamp window, for a code of at most 1543, the magnitude is |code − 512| clipped to 1023. For example, code 0 gives 512, code 1534 gives 1022, and codes 1535 to 1543 give 1023.
- R5: In the clamp window, a code above 1543 gives magnitude 1023 and direction 1.
- R6: In the clamp window, the direction bit is 1 (discharge) for a code above 512 and 0 (charge) for a code below 512.
- R7: In the clamp window, a code of exactly 512 gives magnitude 0 and leaves the direction bit unchanged.
- R8: The two channels share the strobe and standby inputs but have independent error paths. Channel A's outputs depend only on `codeA`, and channel B's only on `codeB`.
- R9: All outputs are registered. A value applied at the inputs before a rising clock edge appears at the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Standby; masks the clamp strobe when high |
| clampN | input | 1 | Optical-black clamp strobe, active low, shared by both channels |
| codeA | input | 14 | Channel A converter code, straight binary |
| codeB | input | 14 | Channel B converter code, straight binary |
| signA | output | 1 | Channel A direction: 1 = discharge, 0 = charge |
| magA | output | 10 | Channel A DAC magnitude |
| signB | output | 1 | Channel B direction |
| magB | output | 10 | Channel B DAC magnitude |

## Verification
Random codes spread across the full 14-bit range, with the strobe and standby toggled at random, separate the proportional region from the saturated region. Giving the two channels different codes shows whether their error paths are truly independent. Directed codes at 0, 511, 512, 513, 1534, 1535, 1543 and 1544 pin down the clip point, the saturation threshold and the hold-on-equal rule. A behavioural plant started far above black, and a second one started below it, show that the registered one-cycle delay still lets the closed loop settle within a couple of codes of 512 from either direction.

// File: rtl/oblk_pkg.sv
package oblk_pkg;
  // Strobes from the control module to each channel datapath
  typedef struct packed {
    logic clear;   // synchronous reset of the channel registers
    logic update;  // clamp window open and not masked by standby
  } oblkStrobes_t;
endpackage

// File: rtl/oblk_ctrl.sv
module oblk_ctrl
  import oblk_pkg::*;
(
  input  logic         rst,
  input  logic         standby,
  input  logic         clampN,
  output oblkStrobes_t strobes
);
  // standby forces the clamp strobe inactive for both channels
  logic windowOpen;

  always_comb begin
    windowOpen     = ~clampN & ~standby;
    strobes.clear  = rst;
    strobes.update = windowOpen & ~rst;
  end
endmodule

// File: rtl/oblk_chan.sv
module oblk_chan
  import oblk_pkg::*;
#(
  parameter int CODE_W  = 14,
  parameter int MAG_W   = 10,
  parameter int TARGET  = 512,
  parameter int SAT_THR = 1543,
  parameter int SHIFT   = 0
) (
  input  logic              clk,
  input  oblkStrobes_t      strobes,
  input  logic [CODE_W-1:0] code,
  output logic              sign,
  output logic [MAG_W-1:0]  mag
);
  localparam logic [CODE_W-1:0] TGT    = CODE_W'(TARGET);
  localparam logic [CODE_W-1:0] THR    = CODE_W'(SAT_THR);
  localparam logic [MAG_W-1:0]  MAGMAX = '1;
  localparam logic [CODE_W-1:0] MAGLIM = {{(CODE_W-MAG_W){1'b0}}, MAGMAX};

  logic              above, below, sat;
  logic [CODE_W-1:0] diff, scaled;
  logic [MAG_W-1:0]  clipped, nextMag;

  always_comb begin
    above   = code > TGT;
    below   = code < TGT;
    sat     = code > THR;
    diff    = above ? (code - TGT) : (TGT - code);
    scaled  = diff >> SHIFT;
    clipped = (scaled > MAGLIM) ? MAGMAX : scaled[MAG_W-1:0];
    nextMag = sat ? MAGMAX : clipped;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      mag  <= '0;
      sign <= 1'b0;
    end else if (strobes.update) begin
      mag <= nextMag;
      if (sat || above)
        sign <= 1'b1;
      else if (below)
        sign <= 1'b0;
    end else begin
      mag <= '0;
    end
  end

  // R1: clear empties the command
  a_r1_clear: assert property (@(posedge clk)
    strobes.clear |=> (mag == '0) && !sign);

  // R2: closed window gives idle magnitude and held direction
  a_r2_idle: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.update |=> (mag == '0) && $stable(sign));

  // R5: saturated region drives full discharge
  a_r5_saturate: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.update && (code > THR)) |=> (mag == MAGMAX) && sign);

  // R6: codes below target charge
  a_r6_charge: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.update && (code < TGT)) |=> !sign);

  // R7: exact target keeps direction and zeroes magnitude
  a_r7_equal_hold: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.update && (code == TGT)) |=> (mag == '0) && $stable(sign));
endmodule

// File: rtl/oblk_clamp_loop.sv
module oblk_clamp_loop
  import oblk_pkg::*;
#(
  parameter int CODE_W  = 14,
  parameter int MAG_W   = 10,
  parameter int TARGET  = 512,
  parameter int SAT_THR = 1543,
  parameter int SHIFT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              clampN,
  input  logic [CODE_W-1:0] codeA,
  input  logic [CODE_W-1:0] codeB,
  output logic              signA,
  output logic [MAG_W-1:0]  magA,
  output logic              signB,
  output logic [MAG_W-1:0]  magB
);
  localparam int NCH = 2;

  oblkStrobes_t      strobes;
  logic [CODE_W-1:0] codeArr [NCH];
  logic              signArr [NCH];
  logic [MAG_W-1:0]  magArr  [NCH];

  always_comb begin
    codeArr[0] = codeA;
    codeArr[1] = codeB;
    signA      = signArr[0];
    magA       = magArr[0];
    signB      = signArr[1];
    magB       = magArr[1];
  end

  oblk_ctrl u_ctrl (
    .rst     (rst),
    .standby (standby),
    .clampN  (clampN),
    .strobes (strobes)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    oblk_chan #(
      .CODE_W  (CODE_W),
      .MAG_W   (MAG_W),
      .TARGET  (TARGET),
      .SAT_THR (SAT_THR),
      .SHIFT   (SHIFT)
    ) u_chan (
      .clk     (clk),
      .strobes (strobes),
      .code    (codeArr[ch]),
      .sign    (signArr[ch]),
      .mag     (magArr[ch])
    );
  end

  // R3: standby masks the strobe on both channels
  a_r3_standby_mask: assert property (@(posedge clk) disable iff (rst)
    standby |=> (magA == '0) && (magB == '0) && $stable(signA) && $stable(signB));

  // R8: a closed window idles both channels together
  a_r8_shared_idle: assert property (@(posedge clk) disable iff (rst)
    clampN |=> (magA == '0) && (magB == '0));
endmodule

// File: tb/oblk_clamp_loop_tb.sv
module oblk_clamp_loop_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b0;
  logic        clampN = 1'b1;
  logic [13:0] codeA = '0;
  logic [13:0] codeB = '0;
  logic        signA, signB;
  logic [9:0]  magA, magB;

  int checks = 0;
  int errors = 0;
  logic expSignA = 1'b0;
  logic expSignB = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  oblk_clamp_loop u_dut (
    .clk(clk), .rst(rst), .standby(standby), .clampN(clampN),
    .codeA(codeA), .codeB(codeB),
    .signA(signA), .magA(magA), .signB(signB), .magB(magB)
  );

  function automatic int expMag(input int code);
    int d;
    if (code > 1543) return 1023;
    d = (code > 512) ? code - 512 : 512 - code;
    return (d > 1023) ? 1023 : d;
  endfunction

  function automatic logic nextSign(input int code, input logic prev);
    if (code > 512) return 1'b1;
    if (code < 512) return 1'b0;
    return prev;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at negedge, check after the next rising edge (R9: one register)
  task automatic step(input int ca, input int cb, input logic cl, input logic sb,
                      input string req);
    logic open;
    int em_a, em_b;
    codeA = 14'(ca); codeB = 14'(cb); clampN = cl; standby = sb;
    open = !cl && !sb;
    @(negedge clk);
    em_a = open ? expMag(ca) : 0;
    em_b = open ? expMag(cb) : 0;
    if (open) begin
      expSignA = nextSign(ca, expSignA);
      expSignB = nextSign(cb, expSignB);
    end
    check({req, " magA"}, int'(magA), em_a);
    check({req, " magB"}, int'(magB), em_b);
    check({req, " signA"}, int'(signA), int'(expSignA));
    check({req, " signB"}, int'(signB), int'(expSignB));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int plantA, plantB, r;
    void'($urandom(32'd20251));
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1 reset magA", int'(magA), 0);
    check("R1 reset signA", int'(signA), 0);
    check("R1 reset magB", int'(magB), 0);
    check("R1 reset signB", int'(signB), 0);
    rst = 1'b0;

    // R4/R6 directed boundaries, R8 with different channel codes
    step(0, 1000, 1'b0, 1'b0, "R4 code0/R8");
    step(511, 513, 1'b0, 1'b0, "R6 511/513");
    step(1534, 100, 1'b0, 1'b0, "R4 1534 clip-1");
    step(1535, 1543, 1'b0, 1'b0, "R4 clip point");
    step(1544, 16383, 1'b0, 1'b0, "R5 saturate");
    step(100, 1544, 1'b0, 1'b0, "R5/R8 mixed");
    // R7: equal target holds sign (A was 0, B was 1)
    step(512, 512, 1'b0, 1'b0, "R7 equal hold");
    step(2000, 300, 1'b0, 1'b0, "R6 set");
    step(512, 512, 1'b0, 1'b0, "R7 equal hold2");
    // R2: closed window idles, sign holds
    step(5000, 0, 1'b1, 1'b0, "R2 window closed");
    // R3: standby masks open strobe
    step(0, 5000, 1'b0, 1'b1, "R3 standby mask");
    step(0, 5000, 1'b1, 1'b1, "R3 standby closed");
    step(700, 400, 1'b0, 1'b0, "R9 reopen");

    // R1: mid-run reset
    codeA = 14'd3000; codeB = 14'd0; clampN = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset magA", int'(magA), 0);
    check("R1 mid reset signA", int'(signA), 0);
    check("R1 mid reset magB", int'(magB), 0);
    rst = 1'b0; expSignA = 1'b0; expSignB = 1'b0;

    // Random mix, R4/R5/R6/R8 and R2/R3 gating
    for (int i = 0; i < 3000; i++) begin
      int ca, cb;
      r = $urandom_range(0, 3);
      ca = (r == 0) ? $urandom_range(0, 16383) :
           (r == 1) ? $urandom_range(400, 624) : $urandom_range(0, 2100);
      cb = (r == 3) ? 512 : $urandom_range(0, 2100);
      step(ca, cb, ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0),
           "R4/R5/R6/R8 random");
    end

    // Closed-loop plant: each command moves the code by half its magnitude
    plantA = 6000; plantB = 100;
    for (int i = 0; i < 60; i++) begin
      step(plantA, plantB, 1'b0, 1'b0, "R4/R9 plant");
      if (magA != 0) plantA += signA ? -((int'(magA) + 1) / 2) : ((int'(magA) + 1) / 2);
      if (magB != 0) plantB += signB ? -((int'(magB) + 1) / 2) : ((int'(magB) + 1) / 2);
      if (plantA < 0) plantA = 0;
      if (plantB < 0) plantB = 0;
      if (plantA > 16383) plantA = 16383;
      if (plantB > 16383) plantB = 16383;
    end
    check("R4 plant A settles", int'((plantA > 509) && (plantA < 515)), 1);
    check("R4 plant B settles", int'((plantB > 509) && (plantB < 515)), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule